// File: doc/BRIEF.md
# Token-Ordered Multi-Source Merge Unit

This block sits in front of one sink unit that is fed by several upstream producers working in parallel. Each producer writes into its own input queue, and the merge unit drains only one of those queues at a time. A producer marks the end of its share of the ordered stream by writing a switch token into the queue. When that token reaches the head of the currently drained queue, the merge unit discards it and moves to the next producer in round-robin order. The sink therefore receives items in the original submission order, even though the producers ran concurrently.

The source is never chosen by arbitration. Items that sit in a queue that is not being drained stay there, even when the drained queue is empty. Output backpressure halts all dequeuing. A producer watches its own queue's full flag and holds back while that flag is set. Because every producer sends its token to every sink, all sink units step through the producers at the same points of the stream.

Top module: `ordered_merge`

## Requirements
- R1: After reset, producer 0 is the active source (`cur_src` = 0), every queue reports empty and none reports full, and `out_valid` is low.
- R2: Only the active source's queue is dequeued. Entries in every other queue stay where they are, and they produce no output even while the active queue is empty.
- R3: When a data entry (written with `in_switch` = 0) is at the head of the active queue, `out_valid` is high and `out_data` carries that entry's data. The entry leaves the queue at the first clock edge where `out_ready` is high. Entries of one queue appear in the order they were written.
- R4: When a switch token (written with `in_switch` = 1, data ignored) is at the head of the active queue and `out_ready` is high, the token is removed at that clock edge and is never presented: `out_valid` is low in that cycle. `cur_src` then moves from i to i+1, and from NUM_SRC-1 back to 0.
- R5: While `out_ready` is low, no queue is dequeued and `cur_src` does not change, whether a data entry or a token is at the head.
- R6: Each queue holds up to DEPTH entries. Its `q_full` bit is high exactly when DEPTH entries are stored, and its `q_empty` bit is high exactly when none are stored. Bit i of each flag vector belongs to producer i.
- R7: A write to a queue whose full flag is high is dropped, and that queue's contents are unchanged.
- R8: A write and a dequeue on the same non-full queue in the same cycle both take effect, so the queue's occupancy is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_push | input | NUM_SRC | Per-producer write strobe |
| in_switch | input | NUM_SRC | Per-producer flag: the entry written is a switch token |
| in_data | input | NUM_SRC*DATA_W | Per-producer write data; producer i uses bits [i*DATA_W +: DATA_W] |
| q_full | output | NUM_SRC | Per-queue full flag |
| q_empty | output | NUM_SRC | Per-queue empty flag |
| out_valid | output | 1 | A data item is presented |
| out_ready | input | 1 | The sink accepts the presented item |
| out_data | output | DATA_W | Presented data item |
| cur_src | output | idx_w(NUM_SRC) | Index of the active producer |

## Verification
Two kinds of event can land in the same cycle. A write can hit the active queue at the very edge where that queue's head is dequeued, or a write can hit a queue that is full. A switch token can also be consumed while other producers keep writing, and while the sink toggles its ready. The bench provokes these cases in directed steps and then in a long pseudo-random sweep over three producers with four-entry queues. It steers writes, tokens and ready from a shift-register sequence. Every cycle it compares the active index, each queue's flags and the presented item against a queue model that it keeps itself.

// File: rtl/om_pkg.sv
package om_pkg;

    typedef enum logic {
        ENTRY_DATA   = 1'b0,
        ENTRY_SWITCH = 1'b1
    } entry_kind_e;

    function automatic int idx_w(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/om_queue.sv
module om_queue #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                push,
    input  om_pkg::entry_kind_e push_kind,
    input  logic [DATA_W-1:0]   push_data,
    input  logic                pop,
    output om_pkg::entry_kind_e head_kind,
    output logic [DATA_W-1:0]   head_data,
    output logic                full,
    output logic                empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_MAX   = CNT_W'(DEPTH);

    typedef struct packed {
        logic [PTR_W-1:0] rd;
        logic [PTR_W-1:0] wr;
        logic [CNT_W-1:0] cnt;
    } qstate_t;

    qstate_t s_d, s_q;
    om_pkg::entry_kind_e kind_mem [DEPTH];
    logic [DATA_W-1:0]   data_mem [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        full    = (s_q.cnt == CNT_MAX);
        empty   = (s_q.cnt == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;
        s_d     = s_q;
        if (do_push) s_d.wr = (s_q.wr == LAST_SLOT) ? '0 : s_q.wr + 1'b1;
        if (do_pop)  s_d.rd = (s_q.rd == LAST_SLOT) ? '0 : s_q.rd + 1'b1;
        case ({do_push, do_pop})
            2'b10:   s_d.cnt = s_q.cnt + 1'b1;
            2'b01:   s_d.cnt = s_q.cnt - 1'b1;
            default: s_d.cnt = s_q.cnt;
        endcase
        head_kind = kind_mem[s_q.rd];
        head_data = data_mem[s_q.rd];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            kind_mem[s_q.wr] <= push_kind;
            data_mem[s_q.wr] <= push_data;
        end
    end
endmodule

// File: rtl/om_pointer.sv
module om_pointer #(
    parameter int NUM_SRC = 3,
    parameter int SRC_W   = om_pkg::idx_w(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_empty,
    input  logic [NUM_SRC-1:0] src_is_switch,
    input  logic               sink_ready,
    output logic [SRC_W-1:0]   active,
    output logic [NUM_SRC-1:0] pop_vec,
    output logic               item_valid
);
    localparam logic [SRC_W-1:0] LAST_SRC = SRC_W'(NUM_SRC - 1);

    typedef struct packed {
        logic [SRC_W-1:0] act;
    } pstate_t;

    pstate_t s_d, s_q;
    logic head_present;
    logic head_switch;

    always_comb begin
        s_d          = s_q;
        head_present = !src_empty[s_q.act];
        head_switch  = src_is_switch[s_q.act];
        item_valid   = head_present && !head_switch;
        pop_vec      = '0;
        if (head_present && sink_ready) begin
            pop_vec[s_q.act] = 1'b1;
            if (head_switch)
                s_d.act = (s_q.act == LAST_SRC) ? '0 : s_q.act + 1'b1;
        end
        active = s_q.act;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/ordered_merge.sv
module ordered_merge #(
    parameter int NUM_SRC = 3,
    parameter int DATA_W  = 8,
    parameter int DEPTH   = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_SRC-1:0]          in_push,
    input  logic [NUM_SRC-1:0]          in_switch,
    input  logic [NUM_SRC*DATA_W-1:0]   in_data,
    output logic [NUM_SRC-1:0]          q_full,
    output logic [NUM_SRC-1:0]          q_empty,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic [DATA_W-1:0]           out_data,
    output logic [om_pkg::idx_w(NUM_SRC)-1:0] cur_src
);
    localparam int SRC_W = om_pkg::idx_w(NUM_SRC);

    logic [NUM_SRC-1:0] pop_vec;
    logic [NUM_SRC-1:0] is_switch;
    logic [DATA_W-1:0]  head_data [NUM_SRC];

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        om_pkg::entry_kind_e wr_kind, hd_kind;
        assign wr_kind      = in_switch[g] ? om_pkg::ENTRY_SWITCH : om_pkg::ENTRY_DATA;
        assign is_switch[g] = (hd_kind == om_pkg::ENTRY_SWITCH);

        om_queue #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_queue (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (in_push[g]),
            .push_kind (wr_kind),
            .push_data (in_data[g*DATA_W +: DATA_W]),
            .pop       (pop_vec[g]),
            .head_kind (hd_kind),
            .head_data (head_data[g]),
            .full      (q_full[g]),
            .empty     (q_empty[g])
        );
    end

    om_pointer #(.NUM_SRC(NUM_SRC), .SRC_W(SRC_W)) u_pointer (
        .clk           (clk),
        .rst_n         (rst_n),
        .src_empty     (q_empty),
        .src_is_switch (is_switch),
        .sink_ready    (out_ready),
        .active        (cur_src),
        .pop_vec       (pop_vec),
        .item_valid    (out_valid)
    );

    assign out_data = head_data[cur_src];
endmodule

// File: rtl/om_checker.sv
module om_checker #(
    parameter int NUM_SRC = 3,
    parameter int DATA_W  = 8,
    parameter int SRC_W   = om_pkg::idx_w(NUM_SRC)
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_SRC-1:0] q_full,
    input logic [NUM_SRC-1:0] q_empty,
    input logic               out_valid,
    input logic               out_ready,
    input logic [DATA_W-1:0]  out_data,
    input logic [SRC_W-1:0]   cur_src
);
    localparam logic [SRC_W-1:0] LAST_SRC = SRC_W'(NUM_SRC - 1);

    assert_hold_when_stalled_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !out_ready |=> $stable(cur_src));

    assert_valid_needs_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !q_empty[cur_src]);

    assert_item_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

    assert_switch_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_ready && !out_valid && !q_empty[cur_src]) |=>
        (cur_src == (($past(cur_src) == LAST_SRC) ? '0 : $past(cur_src) + 1'b1)));

    assert_move_needs_token_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_src != $past(cur_src)) |-> $past(out_ready && !out_valid));

    assert_src_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cur_src <= LAST_SRC);

    assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (q_full & q_empty) == '0);
endmodule

bind ordered_merge om_checker #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W), .SRC_W(SRC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .q_full    (q_full),
    .q_empty   (q_empty),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .cur_src   (cur_src)
);

// File: tb/sim_ordered_merge.sv
module sim_ordered_merge;
    localparam int CLK_PERIOD = 10;
    localparam int N = 3;
    localparam int W = 8;
    localparam int D = 4;
    localparam int WATCHDOG_CYCLES = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]   in_push = '0;
    logic [N-1:0]   in_switch = '0;
    logic [N*W-1:0] in_data = '0;
    logic [N-1:0]   q_full, q_empty;
    logic           out_valid;
    logic           out_ready = 1'b0;
    logic [W-1:0]   out_data;
    logic [1:0]     cur_src;

    always #(CLK_PERIOD/2) clk = ~clk;

    ordered_merge #(.NUM_SRC(N), .DATA_W(W), .DEPTH(D)) u0 (
        .clk(clk), .rst_n(rst_n), .in_push(in_push), .in_switch(in_switch),
        .in_data(in_data), .q_full(q_full), .q_empty(q_empty),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .cur_src(cur_src)
    );

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    // reference queues: kind 1 = switch token
    int mkind [N][D];
    int mdata [N][D];
    int mcnt  [N];
    int mact;
    bit prev_ready = 1'b1;
    bit prev_push_full = 1'b0;
    bit prev_push_pop = 1'b0;

    task automatic compare(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_outputs(input bit in_rst);
        string tag;
        bit exp_valid;
        exp_valid = (mcnt[mact] > 0) && (mkind[mact][0] == 0);
        if (in_rst) tag = "R1";
        else if (!prev_ready) tag = "R5";
        else if (mcnt[mact] == 0) tag = "R2";
        else if (mkind[mact][0] == 1) tag = "R4";
        else tag = "R3";
        compare(tag, "cur_src", int'(cur_src), mact);
        compare(tag, "out_valid", int'(out_valid), int'(exp_valid));
        if (exp_valid) compare(tag, "out_data", int'(out_data), mdata[mact][0]);
        for (int i = 0; i < N; i++) begin
            string ftag;
            ftag = in_rst ? "R1" : (prev_push_full ? "R7" : (prev_push_pop ? "R8" : "R6"));
            compare(ftag, $sformatf("q_full[%0d]", i), int'(q_full[i]), int'(mcnt[i] == D));
            compare(ftag, $sformatf("q_empty[%0d]", i), int'(q_empty[i]), int'(mcnt[i] == 0));
        end
    endtask

    task automatic model_edge(input logic [N-1:0] p, input logic [N-1:0] t,
                              input logic [N*W-1:0] d, input logic r);
        bit acc [N];
        prev_push_full = 1'b0;
        prev_push_pop = 1'b0;
        for (int i = 0; i < N; i++) begin
            acc[i] = p[i] && (mcnt[i] < D);
            if (p[i] && mcnt[i] == D) prev_push_full = 1'b1;
        end
        if (r && mcnt[mact] > 0) begin
            int a;
            a = mact;
            if (acc[a]) prev_push_pop = 1'b1;
            if (mkind[a][0] == 1) mact = (mact + 1) % N;
            for (int k = 0; k < D - 1; k++) begin
                mkind[a][k] = mkind[a][k+1];
                mdata[a][k] = mdata[a][k+1];
            end
            mcnt[a]--;
        end
        for (int i = 0; i < N; i++) begin
            if (acc[i]) begin
                mkind[i][mcnt[i]] = t[i] ? 1 : 0;
                mdata[i][mcnt[i]] = int'(d[i*W +: W]);
                mcnt[i]++;
            end
        end
        prev_ready = r;
    endtask

    task automatic step(input logic [N-1:0] p, input logic [N-1:0] t,
                        input logic [N*W-1:0] d, input logic r);
        @(negedge clk);
        in_push = p; in_switch = t; in_data = d; out_ready = r;
        #1;
        check_outputs(1'b0);
        model_edge(p, t, d, r);
    endtask

    function automatic logic [N*W-1:0] put(input int src, input int val);
        logic [N*W-1:0] v;
        v = '0;
        v[src*W +: W] = W'(val);
        return v;
    endfunction

    initial begin
        logic [15:0] lfsr;
        for (int i = 0; i < N; i++) mcnt[i] = 0;
        mact = 0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        check_outputs(1'b1);          // R1 reset state
        @(negedge clk);
        rst_n = 1'b1;

        // R2: items on inactive producer 1 are left alone while producer 0 is empty
        step(3'b010, 3'b000, put(1, 8'h11), 1'b1);
        step(3'b010, 3'b000, put(1, 8'h12), 1'b1);
        step(3'b010, 3'b000, put(1, 8'h13), 1'b1);
        step(3'b010, 3'b010, put(1, 8'h00), 1'b1);
        step(3'b000, 3'b000, '0, 1'b1);
        // R7: write to full queue 1 is dropped
        step(3'b010, 3'b000, put(1, 8'h14), 1'b1);
        // R3, R4: producer 0 item then token; then producer 1 drains in order
        step(3'b001, 3'b000, put(0, 8'hA0), 1'b1);
        step(3'b001, 3'b001, put(0, 8'h00), 1'b1);
        repeat (8) step(3'b000, 3'b000, '0, 1'b1);
        // R5: token on producer 2 waits while ready is low
        step(3'b100, 3'b100, '0, 1'b0);
        repeat (3) step(3'b000, 3'b000, '0, 1'b0);
        step(3'b000, 3'b000, '0, 1'b1);
        step(3'b000, 3'b000, '0, 1'b1);
        // R8: write and dequeue on the active queue in one cycle
        step(3'b001, 3'b000, put(0, 8'h55), 1'b0);
        step(3'b001, 3'b000, put(0, 8'h66), 1'b1);
        step(3'b000, 3'b000, '0, 1'b1);
        step(3'b000, 3'b000, '0, 1'b1);

        // pseudo-random sweep over writes, tokens and ready
        lfsr = 16'hACE1;
        for (int c = 0; c < 4000; c++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[2:0], lfsr[9:7] & lfsr[12:10],
                 {lfsr[7:0], lfsr[15:8], lfsr[11:4]}, |lfsr[14:13]);
        end
        repeat (20) step(3'b000, 3'b000, '0, 1'b1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule